// File: doc/BRIEF.md
# Dual-Mode Serial Receive Deframer

This block sits behind a bit-recovery stage. It turns a demodulated serial bit stream into bytes that a microcontroller can read. A bit is sampled only on a clock cycle where the bit strobe is high. No other cycle changes any state or output.

The block has two modes. In synchronous mode every strobed bit is packed, and each group of eight bits becomes one byte. In start-stop mode the receiver waits for a start bit and collects five to eight data bits, least significant first. It then takes an optional parity bit and checks the stop bit.

Completed bytes leave on a valid/ready output. The input is a strobed stream that cannot be stalled, so the output applies no back-pressure upstream. If a new byte arrives while the previous one is still unread, the new byte replaces it and an overflow flag is raised. A handshake on the output (ready high while valid is high) counts as a read. A read clears the valid and overflow flags. Framing and parity status flags accompany each start-stop byte.

Top module: `serial_rx_deframer`

## Requirements
- R1: After reset, rx_valid, rx_ovf, frm_err and even_par are 0 and rx_data is 0.
- R2: With sync_mode=1, eight strobed bits form one byte with the first bit in bit 0. rx_valid rises and rx_data holds the byte one clock after the strobe of the eighth bit.
- R3: With sync_mode=0, a strobed 0 on an idle line is a start bit. The next MIN_LEN+len_sel strobed bits are data bits (len_sel 0,1,2,3 selects 5,6,7,8 bits), first bit in bit 0. Unused upper bits of rx_data read 0.
- R4: With par_en=1, one parity bit follows the data bits. It never appears in rx_data. The stop bit comes after it.
- R5: Each start-stop byte sets even_par to 1 exactly when the data bits, plus the parity bit if enabled, hold an even number of ones. A byte received in synchronous mode leaves even_par and frm_err unchanged.
- R6: A stop bit sampled as 0 still delivers the byte and sets rx_valid. It also sets frm_err. frm_err then holds, even through reads, until the next start-stop byte, which sets it from that byte's stop bit.
- R7: After a 0 stop bit, further strobed 0s start no character. A strobed 1 must be seen first, and the next strobed 0 is then a start bit.
- R8: A byte delivered while rx_valid is 1 and no read takes place in that cycle sets rx_ovf. The byte replaces rx_data. rx_ovf is never 1 while rx_valid is 0.
- R9: A read (rx_ready=1 while rx_valid=1) with no byte delivered in the same cycle clears rx_valid and rx_ovf at the next clock. If a byte is delivered in the same cycle as the read, rx_valid stays 1, rx_ovf stays 0 and rx_data takes the new byte.
- R10: On a cycle with bit_stb=0, no byte is delivered, whatever bit_in does. rx_data, frm_err and even_par keep their values at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Recovered serial bit |
| bit_stb | input | 1 | Bit strobe; bit_in is sampled when high |
| sync_mode | input | 1 | 1 = synchronous packing, 0 = start-stop characters |
| len_sel | input | LEN_W (2) | Data bits per character minus MIN_LEN |
| par_en | input | 1 | 1 = a parity bit follows the data bits |
| rx_data | output | DATA_W (8) | Last delivered byte, zero-extended |
| rx_valid | output | 1 | Unread byte present |
| rx_ready | input | 1 | Read request; consumes the byte when rx_valid is 1 |
| rx_ovf | output | 1 | An unread byte was overwritten |
| frm_err | output | 1 | Last start-stop byte had a 0 stop bit |
| even_par | output | 1 | Last start-stop byte had even parity over data and parity bits |

## Verification
The bench uses the default parameters: DATA_W=8, MIN_LEN=5 and LEN_W=2. With these values every legal character length, from five up to the full byte width, can be selected through len_sel. Synchronous bytes fill the whole register. The bench covers the five-bit and seven-bit lengths with parity and the eight-bit length without it. This brings zero-extension, exclusion of the parity bit and even-parity reporting within reach in one short run. A byte delivered on the same cycle as a read shows the priority of a new byte over a read.

// File: rtl/rxu_pkg.sv
package rxu_pkg;
  typedef enum logic [2:0] {
    SS_IDLE,
    SS_DATA,
    SS_PAR,
    SS_STOP,
    SS_HUNT
  } ss_state_e;
endpackage

// File: rtl/rxu_sync_packer.sv
module rxu_sync_packer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              stb,
  input  logic              bit_in,
  output logic              xfer_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] acc_w;

  // current bit merged into its slot, so the last bit is part of the byte
  always_comb begin
    acc_w = acc_q;
    acc_w[cnt_q] = bit_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (stb) begin
      acc_q <= acc_w;
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign xfer_o = en && stb && (cnt_q == LAST);
  assign data_o = acc_w;
endmodule

// File: rtl/rxu_frame_fsm.sv
module rxu_frame_fsm
  import rxu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MIN_LEN = 5,
  parameter int LEN_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              stb,
  input  logic              bit_in,
  input  logic [LEN_W-1:0]  len_sel,
  input  logic              par_en,
  output logic              xfer_o,
  output logic [DATA_W-1:0] data_o,
  output logic              stop_bad_o,
  output logic              even_par_o
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int LV_W  = $clog2(DATA_W + 1) + 1;

  ss_state_e         st_q;
  logic [LV_W-1:0]   cnt_q;
  logic [LV_W-1:0]   len_last;
  logic [DATA_W-1:0] shreg_q;
  logic              odd_q;

  assign len_last = LV_W'(MIN_LEN) + LV_W'(len_sel) - LV_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= SS_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
      odd_q   <= 1'b0;
    end else if (!en) begin
      st_q <= SS_IDLE;
    end else if (stb) begin
      case (st_q)
        SS_IDLE: begin
          if (!bit_in) begin
            st_q    <= SS_DATA;
            cnt_q   <= '0;
            shreg_q <= '0;
            odd_q   <= 1'b0;
          end
        end
        SS_DATA: begin
          shreg_q[cnt_q[CNT_W-1:0]] <= bit_in;
          odd_q <= odd_q ^ bit_in;
          if (cnt_q == len_last) begin
            st_q <= par_en ? SS_PAR : SS_STOP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SS_PAR: begin
          odd_q <= odd_q ^ bit_in;
          st_q  <= SS_STOP;
        end
        SS_STOP: st_q <= bit_in ? SS_IDLE : SS_HUNT;
        SS_HUNT: if (bit_in) st_q <= SS_IDLE;
        default: st_q <= SS_IDLE;
      endcase
    end
  end

  assign xfer_o     = en && stb && (st_q == SS_STOP);
  assign data_o     = shreg_q;
  assign stop_bad_o = ~bit_in;
  assign even_par_o = ~odd_q;
endmodule

// File: rtl/rxu_status_regs.sv
module rxu_status_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer,
  input  logic [DATA_W-1:0] xfer_data,
  input  logic              ss_upd,
  input  logic              stop_bad,
  input  logic              even_in,
  input  logic              rd,
  output logic [DATA_W-1:0] data_q,
  output logic              valid_q,
  output logic              ovf_q,
  output logic              frm_q,
  output logic              even_q
);
  logic rd_fire;
  assign rd_fire = rd && valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
      frm_q   <= 1'b0;
      even_q  <= 1'b0;
    end else begin
      if (xfer) data_q <= xfer_data;
      if (xfer)         valid_q <= 1'b1;
      else if (rd_fire) valid_q <= 1'b0;
      if (xfer && valid_q && !rd) ovf_q <= 1'b1;
      else if (rd_fire)           ovf_q <= 1'b0;
      if (ss_upd) begin
        frm_q  <= stop_bad;
        even_q <= even_in;
      end
    end
  end
endmodule

// File: rtl/serial_rx_deframer.sv
module serial_rx_deframer #(
  parameter int DATA_W  = 8,
  parameter int MIN_LEN = 5,
  parameter int LEN_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  input  logic              bit_stb,
  input  logic              sync_mode,
  input  logic [LEN_W-1:0]  len_sel,
  input  logic              par_en,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              rx_ovf,
  output logic              frm_err,
  output logic              even_par
);
  logic              sy_xfer, ss_xfer, ss_stop_bad, ss_even;
  logic [DATA_W-1:0] sy_data, ss_data;

  rxu_sync_packer #(.DATA_W(DATA_W)) packer_i (
    .clk(clk), .rst_n(rst_n), .en(sync_mode), .stb(bit_stb),
    .bit_in(bit_in), .xfer_o(sy_xfer), .data_o(sy_data)
  );

  rxu_frame_fsm #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W)) frame_i (
    .clk(clk), .rst_n(rst_n), .en(~sync_mode), .stb(bit_stb),
    .bit_in(bit_in), .len_sel(len_sel), .par_en(par_en),
    .xfer_o(ss_xfer), .data_o(ss_data), .stop_bad_o(ss_stop_bad),
    .even_par_o(ss_even)
  );

  rxu_status_regs #(.DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .xfer(sy_xfer | ss_xfer),
    .xfer_data(sync_mode ? sy_data : ss_data),
    .ss_upd(ss_xfer), .stop_bad(ss_stop_bad), .even_in(ss_even),
    .rd(rx_ready),
    .data_q(rx_data), .valid_q(rx_valid), .ovf_q(rx_ovf),
    .frm_q(frm_err), .even_q(even_par)
  );
endmodule

// File: rtl/rxu_checker.sv
module rxu_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_stb,
  input logic              sync_mode,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              rx_ovf,
  input logic              frm_err,
  input logic              even_par
);
  // R10
  strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(rx_data) && $stable(frm_err) && $stable(even_par)
                 && !$rose(rx_valid) && !$rose(rx_ovf));
  // R9
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready && !bit_stb |=> !rx_valid && !rx_ovf);
  // R8
  ovf_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf |-> rx_valid);
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovf) |-> $past(rx_valid) && !$past(rx_ready));
  // R5
  sync_keeps_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode |=> $stable(even_par) && $stable(frm_err));
endmodule

bind serial_rx_deframer rxu_checker #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .sync_mode(sync_mode),
  .rx_ready(rx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
  .rx_ovf(rx_ovf), .frm_err(frm_err), .even_par(even_par)
);

// File: tb/serial_rx_deframer_tb_top.sv
module serial_rx_deframer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_in = 1'b1;
  logic       bit_stb = 1'b0;
  logic       sync_mode = 1'b1;
  logic [1:0] len_sel = 2'd3;
  logic       par_en = 1'b0;
  logic       rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, rx_ovf, frm_err, even_par;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  serial_rx_deframer dut_i (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_stb(bit_stb),
    .sync_mode(sync_mode), .len_sel(len_sel), .par_en(par_en),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_ovf(rx_ovf), .frm_err(frm_err), .even_par(even_par)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input logic rd);
    @(negedge clk);
    bit_in = b; bit_stb = 1'b1; rx_ready = rd;
    @(negedge clk);
    bit_stb = 1'b0; rx_ready = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_sync(input logic [7:0] d, input logic rd_last);
    for (int i = 0; i < 8; i++) send_bit(d[i], (i == 7) && rd_last);
  endtask

  task automatic send_frame(input logic [7:0] d, input int n, input logic pe,
                            input logic pb, input logic sb);
    send_bit(1'b0, 1'b0);
    for (int i = 0; i < n; i++) send_bit(d[i], 1'b0);
    if (pe) send_bit(pb, 1'b0);
    send_bit(sb, 1'b0);
  endtask

  task automatic do_read();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 valid", rx_valid, 0);
    check("R1 ovf", rx_ovf, 0);
    check("R1 frm", frm_err, 0);
    check("R1 even", even_par, 0);
    check("R1 data", rx_data, 0);
  endtask

  task automatic t_sync_basic();
    sync_mode = 1'b1;
    send_sync(8'hA5, 1'b0);
    check("R2 valid", rx_valid, 1);
    check("R2 data A5", rx_data, 8'hA5);
    do_read();
    check("R9 read clears valid", rx_valid, 0);
    // seven bits, then bit_in toggles without strobe
    for (int i = 0; i < 7; i++) send_bit(1'b1, 1'b0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); bit_in = ~bit_in;
    end
    check("R10 no byte without strobe", rx_valid, 0);
    send_bit(1'b0, 1'b0);
    check("R2 data 7F", rx_data, 8'h7F);
    check("R2 valid 7F", rx_valid, 1);
    do_read();
  endtask

  task automatic t_overflow();
    send_sync(8'h3C, 1'b0);
    send_sync(8'hC3, 1'b0);
    check("R8 ovf set", rx_ovf, 1);
    check("R8 data replaced", rx_data, 8'hC3);
    do_read();
    check("R9 ovf cleared", rx_ovf, 0);
    check("R9 valid cleared", rx_valid, 0);
  endtask

  task automatic t_read_same_cycle();
    send_sync(8'h11, 1'b0);
    send_sync(8'h96, 1'b1);
    check("R9 valid kept", rx_valid, 1);
    check("R9 no ovf", rx_ovf, 0);
    check("R9 new data", rx_data, 8'h96);
    do_read();
  endtask

  task automatic t_ss_lengths();
    sync_mode = 1'b0;
    bit_in = 1'b1;
    len_sel = 2'd3; par_en = 1'b0;
    send_bit(1'b1, 1'b0);
    send_frame(8'h5A, 8, 1'b0, 1'b0, 1'b1);
    check("R3 data 5A", rx_data, 8'h5A);
    check("R5 even 5A", even_par, 1);
    check("R6 frm clear", frm_err, 0);
    do_read();
    len_sel = 2'd0; par_en = 1'b1;
    send_frame(8'h13, 5, 1'b1, 1'b1, 1'b1);
    check("R4 parity excluded", rx_data, 8'h13);
    check("R5 even with parity", even_par, 1);
    do_read();
    len_sel = 2'd2;
    send_frame(8'h7F, 7, 1'b1, 1'b0, 1'b1);
    check("R3 data 7 bits", rx_data, 8'h7F);
    check("R5 odd count", even_par, 0);
    do_read();
  endtask

  task automatic t_framing();
    len_sel = 2'd3; par_en = 1'b0;
    send_frame(8'h33, 8, 1'b0, 1'b0, 1'b0);
    check("R6 delivered", rx_valid, 1);
    check("R6 data 33", rx_data, 8'h33);
    check("R6 frm set", frm_err, 1);
    do_read();
    check("R6 frm sticky on read", frm_err, 1);
    for (int i = 0; i < 10; i++) send_bit(1'b0, 1'b0);
    check("R7 no start during low line", rx_valid, 0);
    send_bit(1'b1, 1'b0);
    send_frame(8'h81, 8, 1'b0, 1'b0, 1'b1);
    check("R7 resync data", rx_data, 8'h81);
    check("R6 frm cleared by next char", frm_err, 0);
    do_read();
  endtask

  task automatic t_sync_keeps_status();
    // even_par is 1 here from the last start-stop byte (81)
    sync_mode = 1'b1;
    send_sync(8'h01, 1'b0);
    check("R5 sync data", rx_data, 8'h01);
    check("R5 even unchanged in sync", even_par, 1);
    do_read();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired R1..all");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_sync_basic();
    t_overflow();
    t_read_same_cycle();
    t_ss_lengths();
    t_framing();
    t_sync_keeps_status();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule